// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Status Tracking

This block takes an asynchronous serial line and turns it back into characters. It samples the line against a 16x oversample tick and accepts frames of 5 to 8 data bits, with optional even or odd parity and one or two stop bits. Each received character goes into a receive queue. Parity, framing and break conditions are recorded as tags on the character that caused them. When a condition is reported, it becomes a sticky status flag, and the flag clears when the status register is read.

There are two queue modes. In single-holding mode the queue holds one character. In queued mode it holds sixteen. The two modes report errors the same way: a character's tags become status flags only when that character reaches the head of the queue. In queued mode an aggregate error bit stays set while any tagged character remains stored. A line-status interrupt request is raised when an error flag is set and the interrupt is enabled.

Top module: `serial_rx_status`

## Requirements
- R1: A frame is a low start bit, then the data bits LSB first, then an optional parity bit, then the stop bit or bits. The data bit count is set by `len_sel_i`: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Unused high bits of `rx_data_o` read 0. `data_ready_o` is 1 while a character is held, and `rd_data_i` removes the head character.
- R2: With `par_en_i` set, the parity bit is expected to make the count of ones even when `par_even_i` is 1, and odd when it is 0. A mismatch tags the character with a parity error, shown on `parity_err_o`.
- R3: A stop bit sampled low tags the character with a framing error, shown on `framing_err_o`.
- R4: After a framing error on a non-zero character, the low stop bit is taken as the start bit of the next character. That character is received without any new falling edge.
- R5: A low pulse that has ended by the middle of the start bit (shorter than half a bit) loads no character.
- R6: If the line stays low for longer than one whole frame (start, data, parity and stop bits), exactly one all-zero character is loaded, tagged as a break and shown on `break_o`.
- R7: After a break, a start bit is accepted only after the line has been high for at least half a bit, which is 8 consecutive ticks.
- R8: A pulse on `lsr_rd_i` clears `overrun_o`, `parity_err_o`, `framing_err_o` and `break_o`.
- R9: A character's tags set the status flags only once that character is at the head of the queue. This holds in both modes.
- R10: `fifo_err_o` is 0 in single-holding mode. In queued mode it is set while any stored character is tagged. A status read clears it only if no tagged character remains.
- R11: A character that completes while the queue is full is discarded and sets `overrun_o`. The queue is full at 16 entries in queued mode and at 1 entry in single-holding mode.
- R12: `lsi_irq_o` is 1 when `lsi_en_i` is set and any of the overrun, parity, framing or break flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversample enable, 16 per bit |
| len_sel_i | input | 2 | Data bit count code (5 + code) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| stop2_i | input | 1 | Two stop bits |
| fifo_mode_i | input | 1 | 1 selects the 16-entry queue, 0 selects single holding |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| lsr_rd_i | input | 1 | Status register read strobe |
| rd_data_i | input | 1 | Read (remove) head character |
| rx_data_o | output | 8 | Head character |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Overrun flag |
| parity_err_o | output | 1 | Parity error flag |
| framing_err_o | output | 1 | Framing error flag |
| break_o | output | 1 | Break flag |
| fifo_err_o | output | 1 | Aggregate tagged-character flag |
| lsi_irq_o | output | 1 | Line-status interrupt request |

## Verification
The hardest situations to reach from the ports are the resynchronising path and the recovery after a break. In the first, a low stop bit must also be the start bit of a real next character. In the second, the line must go high briefly and then low again before the half-bit of marking has passed. Random frames cannot produce either shape, so the stimulus drives the line bit by bit. It places the second character's data directly after a low stop bit. After a long low it gives a 4-tick high, then a 16-tick low, then returns the line to idle. Random frames in single-holding mode cover the length and parity combinations.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_tag_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD, ST_MARK
  } rx_st_e;
endpackage

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic [1:0]    len_sel_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  input  logic          stop2_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output rx_tag_t       push_tag_o
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW);
  localparam int MID = OVS / 2 - 1;
  localparam int LCW = $clog2((DW + 4) * OVS + 1);

  rx_st_e         st_q;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  bit_q;
  logic [DW-1:0]  dat_q;
  logic           zero_q, perr_q;
  logic [LCW-1:0] low_q;

  logic [BW:0]    nbits;
  logic           last_bit, exp_par, at_end, at_mid;
  logic [LCW-1:0] frame_len;

  assign nbits     = (BW+1)'(5) + (BW+1)'(len_sel_i);
  assign last_bit  = (bit_q == BW'(nbits - 1'b1));
  assign exp_par   = par_even_i ? ^dat_q : ~^dat_q;
  assign at_end    = (cnt_q == CW'(OVS - 1));
  assign at_mid    = (cnt_q == CW'(MID));
  assign frame_len = LCW'((32'd2 + 32'(nbits) + 32'(par_en_i) + 32'(stop2_i)) * OVS);

  // consecutive low ticks, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= '0;
    else if (tick_i) begin
      if (rx_i) low_q <= '0;
      else if (low_q != '1) low_q <= low_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      dat_q       <= '0;
      zero_q      <= 1'b1;
      perr_q      <= 1'b0;
      push_o      <= 1'b0;
      push_data_o <= '0;
      push_tag_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rx_i) begin
              st_q   <= ST_START;
              cnt_q  <= '0;
              bit_q  <= '0;
              dat_q  <= '0;
              zero_q <= 1'b1;
              perr_q <= 1'b0;
            end
          end
          ST_START: begin
            if (at_mid) begin
              cnt_q <= '0;
              st_q  <= rx_i ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (at_end) begin
              cnt_q        <= '0;
              dat_q[bit_q] <= rx_i;
              zero_q       <= zero_q & ~rx_i;
              if (last_bit) st_q <= par_en_i ? ST_PAR : ST_STOP;
              else bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (at_end) begin
              cnt_q  <= '0;
              perr_q <= (rx_i != exp_par);
              zero_q <= zero_q & ~rx_i;
              st_q   <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (at_end) begin
              cnt_q <= '0;
              if (rx_i) begin
                push_o      <= 1'b1;
                push_data_o <= dat_q;
                push_tag_o  <= '{brk: 1'b0, ferr: 1'b0, perr: perr_q};
                st_q        <= ST_IDLE;
              end else if (zero_q) begin
                st_q <= ST_HOLD;
              end else begin
                // low stop taken as the next start bit, re-checked next tick
                push_o      <= 1'b1;
                push_data_o <= dat_q;
                push_tag_o  <= '{brk: 1'b0, ferr: 1'b1, perr: perr_q};
                st_q        <= ST_START;
                cnt_q       <= CW'(MID);
                bit_q       <= '0;
                dat_q       <= '0;
                zero_q      <= 1'b1;
                perr_q      <= 1'b0;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_HOLD: begin
            if (rx_i) begin
              push_o      <= 1'b1;
              push_data_o <= '0;
              push_tag_o  <= '{brk: 1'b0, ferr: 1'b1, perr: perr_q};
              st_q        <= ST_IDLE;
            end else if (low_q >= frame_len - 1'b1) begin
              push_o      <= 1'b1;
              push_data_o <= '0;
              push_tag_o  <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0};
              st_q        <= ST_MARK;
              cnt_q       <= '0;
            end
          end
          ST_MARK: begin
            if (!rx_i) cnt_q <= '0;
            else if (at_mid) begin
              cnt_q <= '0;
              st_q  <= ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_mode_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  rx_tag_t       tag_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic          ovf_o,
  output logic [DW-1:0] head_data_o,
  output rx_tag_t       head_tag_o,
  output logic          err_any_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = AW + 1;

  typedef struct packed {
    rx_tag_t       tag;
    logic [DW-1:0] data;
  } ent_t;

  ent_t            mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q, ecnt_q;
  logic            full, acc, pop_ok;

  assign full    = hold_mode_i ? (cnt_q != '0) : (cnt_q == CNTW'(DEPTH));
  assign acc     = push_i & ~full;
  assign empty_o = (cnt_q == '0);
  assign pop_ok  = pop_i & ~empty_o;
  assign ovf_o   = push_i & full;

  assign head_data_o = mem_q[rp_q].data;
  assign head_tag_o  = mem_q[rp_q].tag;
  assign err_any_o   = (ecnt_q != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (acc) mem_q[wp_q] <= '{tag: tag_i, data: data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ecnt_q <= '0;
    end else begin
      if (acc)    wp_q <= nxt(wp_q);
      if (pop_ok) rp_q <= nxt(rp_q);
      cnt_q  <= cnt_q + CNTW'(acc) - CNTW'(pop_ok);
      ecnt_q <= ecnt_q + CNTW'(acc & (|tag_i)) - CNTW'(pop_ok & (|head_tag_o));
    end
  end
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fifo_mode_i,
  input  logic    lsr_rd_i,
  input  logic    irq_en_i,
  input  logic    empty_i,
  input  logic    pop_i,
  input  rx_tag_t head_tag_i,
  input  logic    ovf_i,
  input  logic    err_any_i,
  output logic    rep_o,
  output logic    oe_o,
  output logic    pe_o,
  output logic    fe_o,
  output logic    bi_o,
  output logic    fifo_err_o,
  output logic    irq_o
);
  logic seen_q, keep;

  // head tags are merged once, the first cycle the head is visible
  assign rep_o = ~empty_i & ~seen_q;
  assign keep  = ~lsr_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      oe_o       <= 1'b0;
      pe_o       <= 1'b0;
      fe_o       <= 1'b0;
      bi_o       <= 1'b0;
      fifo_err_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      seen_q     <= (pop_i | empty_i) ? 1'b0 : (seen_q | rep_o);
      oe_o       <= (oe_o & keep) | ovf_i;
      pe_o       <= (pe_o & keep) | (rep_o & head_tag_i.perr);
      fe_o       <= (fe_o & keep) | (rep_o & head_tag_i.ferr);
      bi_o       <= (bi_o & keep) | (rep_o & head_tag_i.brk);
      fifo_err_o <= fifo_mode_i & (err_any_i | (fifo_err_o & keep));
      irq_o      <= irq_en_i & (((oe_o & keep) | ovf_i) |
                               ((pe_o & keep) | (rep_o & head_tag_i.perr)) |
                               ((fe_o & keep) | (rep_o & head_tag_i.ferr)) |
                               ((bi_o & keep) | (rep_o & head_tag_i.brk)));
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int SYNC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic [1:0]    len_sel_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  input  logic          stop2_i,
  input  logic          fifo_mode_i,
  input  logic          lsi_en_i,
  input  logic          lsr_rd_i,
  input  logic          rd_data_i,
  output logic [DW-1:0] rx_data_o,
  output logic          data_ready_o,
  output logic          overrun_o,
  output logic          parity_err_o,
  output logic          framing_err_o,
  output logic          break_o,
  output logic          fifo_err_o,
  output logic          lsi_irq_o
);
  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  logic            frm_push;
  logic [DW-1:0]   frm_data;
  rx_tag_t         frm_tag;
  logic            fifo_empty, fifo_ovf, err_any, pop_ok, stat_rep;
  rx_tag_t         head_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC-1];

  rx_frame #(.OVS(OVS), .DW(DW)) u_frm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rx_i       (rx_s),
    .len_sel_i  (len_sel_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .stop2_i    (stop2_i),
    .push_o     (frm_push),
    .push_data_o(frm_data),
    .push_tag_o (frm_tag)
  );

  rx_tag_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_mode_i(~fifo_mode_i),
    .push_i     (frm_push),
    .data_i     (frm_data),
    .tag_i      (frm_tag),
    .pop_i      (rd_data_i),
    .empty_o    (fifo_empty),
    .ovf_o      (fifo_ovf),
    .head_data_o(rx_data_o),
    .head_tag_o (head_tag),
    .err_any_o  (err_any)
  );

  assign pop_ok       = rd_data_i & ~fifo_empty;
  assign data_ready_o = ~fifo_empty;

  rx_line_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_mode_i(fifo_mode_i),
    .lsr_rd_i   (lsr_rd_i),
    .irq_en_i   (lsi_en_i),
    .empty_i    (fifo_empty),
    .pop_i      (pop_ok),
    .head_tag_i (head_tag),
    .ovf_i      (fifo_ovf),
    .err_any_i  (err_any),
    .rep_o      (stat_rep),
    .oe_o       (overrun_o),
    .pe_o       (parity_err_o),
    .fe_o       (framing_err_o),
    .bi_o       (break_o),
    .fifo_err_o (fifo_err_o),
    .irq_o      (lsi_irq_o)
  );
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk
  import rx_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_mode_i,
  input logic          lsi_en_i,
  input logic          lsr_rd_i,
  input logic          overrun_o,
  input logic          parity_err_o,
  input logic          framing_err_o,
  input logic          break_o,
  input logic          fifo_err_o,
  input logic          lsi_irq_o,
  input logic          frm_push_i,
  input logic [DW-1:0] frm_data_i,
  input rx_tag_t       frm_tag_i,
  input logic          ovf_i,
  input logic          rep_i
);
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> overrun_o); // R11

  AST_BREAK_ZERO_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_push_i && frm_tag_i.brk) |-> (frm_data_i == '0)); // R6

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !rep_i) |=> (!parity_err_o && !framing_err_o && !break_o)); // R8

  AST_AGG_ERR_HOLD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && $past(!fifo_mode_i)) |-> !fifo_err_o); // R10

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsi_en_i |=> !lsi_irq_o); // R12
endmodule

bind serial_rx_status serial_rx_status_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_mode_i  (fifo_mode_i),
  .lsi_en_i     (lsi_en_i),
  .lsr_rd_i     (lsr_rd_i),
  .overrun_o    (overrun_o),
  .parity_err_o (parity_err_o),
  .framing_err_o(framing_err_o),
  .break_o      (break_o),
  .fifo_err_o   (fifo_err_o),
  .lsi_irq_o    (lsi_irq_o),
  .frm_push_i   (frm_push),
  .frm_data_i   (frm_data),
  .frm_tag_i    (frm_tag),
  .ovf_i        (fifo_ovf),
  .rep_i        (stat_rep)
);

// File: tb/sim_serial_rx_status.sv
module sim_serial_rx_status;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32; // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, stop2 = 1'b0;
  logic       fifo_mode = 1'b0, lsi_en = 1'b0, lsr_rd = 1'b0, rd_data = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, overrun, parity_err, framing_err, brk, fifo_err, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  serial_rx_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
    .len_sel_i(len_sel), .par_en_i(par_en), .par_even_i(par_even), .stop2_i(stop2),
    .fifo_mode_i(fifo_mode), .lsi_en_i(lsi_en), .lsr_rd_i(lsr_rd), .rd_data_i(rd_data),
    .rx_data_o(rx_data), .data_ready_o(data_ready), .overrun_o(overrun),
    .parity_err_o(parity_err), .framing_err_o(framing_err), .break_o(brk),
    .fifo_err_o(fifo_err), .lsi_irq_o(irq)
  );

  function automatic logic par_of(input logic [7:0] d, input logic ev);
    return ev ? ^d : ~^d;
  endfunction

  function automatic logic [7:0] mask_of(input int n);
    return 8'((16'd1 << n) - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    clks(BIT_CLKS);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad);
    int n;
    n = 5 + int'(len_sel);
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (par_en) send_bit(par_of(d & mask_of(n), par_even) ^ bad);
    send_bit(1'b1);
    if (stop2) send_bit(1'b1);
  endtask

  task automatic lsr_read();
    @(negedge clk) lsr_rd = 1'b1;
    @(negedge clk) lsr_rd = 1'b0;
    clks(3);
  endtask

  task automatic pop();
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
    clks(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic       bad;
    int         n;
    void'($urandom(32'h5EED_1234));
    clks(5);
    rst_n = 1'b1;
    clks(4);

    // reset state
    chk("R1 reset ready", {31'd0, data_ready}, 0);
    chk("R8 reset flags", {28'd0, overrun, parity_err, framing_err, brk}, 0);
    chk("R12 reset irq", {31'd0, irq}, 0);

    // single-holding mode, random frames
    lsi_en = 1'b1;
    for (int it = 0; it < 12; it++) begin
      len_sel  = 2'($urandom_range(0, 3));
      par_en   = 1'($urandom);
      par_even = 1'($urandom);
      stop2    = 1'($urandom);
      n        = 5 + int'(len_sel);
      d        = 8'($urandom) & mask_of(n);
      bad      = par_en & 1'($urandom);
      send_frame(d, bad);
      send_bit(1'b1);
      chk("R1 ready", {31'd0, data_ready}, 1);
      chk("R1 data", {24'd0, rx_data}, {24'd0, d});
      chk("R2 parity flag", {31'd0, parity_err}, {31'd0, bad});
      chk("R3 no framing", {31'd0, framing_err}, 0);
      chk("R12 irq", {31'd0, irq}, {31'd0, bad});
      chk("R10 agg zero in holding", {31'd0, fifo_err}, 0);
      lsr_read();
      chk("R8 cleared", {30'd0, parity_err, irq}, 0);
      pop();
      chk("R1 popped", {31'd0, data_ready}, 0);
    end

    // overrun in holding mode
    len_sel = 2'd3; par_en = 1'b0; stop2 = 1'b0;
    send_frame(8'h61, 1'b0);
    send_frame(8'h62, 1'b0);
    send_bit(1'b1);
    chk("R11 holding overrun", {31'd0, overrun}, 1);
    chk("R11 holding keeps first", {24'd0, rx_data}, 32'h61);
    lsr_read();
    chk("R8 overrun cleared", {31'd0, overrun}, 0);
    pop();

    // queued mode: tag at head only (8E1)
    fifo_mode = 1'b1;
    clks(4);
    par_en = 1'b1; par_even = 1'b1;
    send_frame(8'h11, 1'b0);
    send_frame(8'h22, 1'b1);
    send_bit(1'b1);
    chk("R9 tag hidden behind clean head", {31'd0, parity_err}, 0);
    chk("R10 agg set", {31'd0, fifo_err}, 1);
    pop();
    chk("R9 head data", {24'd0, rx_data}, 32'h22);
    chk("R9 tag shown at head", {31'd0, parity_err}, 1);
    lsr_read();
    chk("R8 parity cleared", {31'd0, parity_err}, 0);
    chk("R10 agg kept while tagged stored", {31'd0, fifo_err}, 1);
    pop();
    chk("R10 agg sticky until read", {31'd0, fifo_err}, 1);
    lsr_read();
    chk("R10 agg cleared", {31'd0, fifo_err}, 0);

    // framing error with resync (8N1)
    par_en = 1'b0;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d_a(i));
    send_bit(1'b0); // low stop, also next start
    for (int i = 0; i < 8; i++) send_bit(d_b(i));
    send_bit(1'b1);
    send_bit(1'b1);
    chk("R3 head data", {24'd0, rx_data}, 32'hA5);
    chk("R3 framing flag", {31'd0, framing_err}, 1);
    lsr_read();
    pop();
    chk("R4 resync char", {24'd0, rx_data}, 32'h5A);
    chk("R4 resync clean", {31'd0, framing_err}, 0);
    pop();
    chk("R4 exactly two", {31'd0, data_ready}, 0);
    lsr_read();

    // short glitch
    rx = 1'b0; clks(8);
    rx = 1'b1; clks(2 * BIT_CLKS);
    chk("R5 glitch ignored", {31'd0, data_ready}, 0);

    // break then short mark then low pulse
    rx = 1'b0; clks(20 * BIT_CLKS);
    rx = 1'b1; clks(8);
    rx = 1'b0; clks(32);
    rx = 1'b1; clks(2 * BIT_CLKS);
    chk("R6 break char present", {31'd0, data_ready}, 1);
    chk("R6 break char zero", {24'd0, rx_data}, 0);
    chk("R6 break flag", {31'd0, brk}, 1);
    pop();
    chk("R7 one char only", {31'd0, data_ready}, 0);
    lsr_read();
    chk("R8 break cleared", {31'd0, brk}, 0);
    send_frame(8'h3C, 1'b0);
    send_bit(1'b1);
    chk("R7 restart after mark", {24'd0, rx_data}, 32'h3C);
    pop();

    // queued overrun
    for (int i = 0; i < 17; i++) send_frame(8'(i * 7 + 1), 1'b0);
    send_bit(1'b1);
    chk("R11 queued overrun", {31'd0, overrun}, 1);
    chk("R12 irq on overrun", {31'd0, irq}, 1);
    lsi_en = 1'b0;
    clks(3);
    chk("R12 irq disabled", {31'd0, irq}, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R11 queued order", {24'd0, rx_data}, 32'(8'(i * 7 + 1)));
      pop();
    end
    chk("R11 17th dropped", {31'd0, data_ready}, 0);
    lsr_read();
    chk("R8 overrun cleared queued", {31'd0, overrun}, 0);

    finish_run();
  end

  function automatic logic d_a(input int i);
    logic [7:0] v = 8'hA5;
    return v[i];
  endfunction

  function automatic logic d_b(input int i);
    logic [7:0] v = 8'h5A;
    return v[i];
  endfunction
endmodule